// File: doc/BRIEF.md
# Radio transceiver state controller

This block sequences the operating state of a low-power packet radio. Software requests state changes by writing a command code. A multifunction sleep/transmit pin moves the radio between certain states on its rising and falling edges, and which move it makes depends on the present state. An active-low reset pin returns the radio to the idle state. Strobes from the receive and transmit datapaths mark frame start and frame completion. The block presents the present state as a 5-bit status code.

Each command-driven or pin-driven change takes `TRANS_DLY` clock cycles. During that time the status shows a reserved in-progress code and further commands are dropped. A pin edge that arrives during a change is kept and acted on once the change is over. Two kinds of command end active receive or transmit. Forcing commands abort the frame. The plain idle command is remembered and carried out when the frame completes.

Top module: `trx_state_ctrl`

## Requirements
- R1: While `rst_ni` is low and just after it is released, `status_o` reads 0x00 (power-on state), `clkm_valid_o` is 0 and `pll_en_o` is 0.
- R2: `clkm_valid_o` rises in the cycle after `osc_stable_i` is first sampled high and then stays high, except that it reads 0 whenever `status_o` shows SLEEP (0x0F).
- R3: An accepted change makes `status_o` read 0x1F for exactly `TRANS_DLY` cycles, starting the cycle after acceptance, and then read the target code. The codes are P_ON 0x00, BUSY_RX 0x01, BUSY_TX 0x02, RX_ON 0x06, TRX_OFF 0x08, PLL_ON 0x09, SLEEP 0x0F and RX_ON_NOCLK 0x1C.
- R4: A command presented while `status_o` reads 0x1F is discarded and has no later effect.
- R5: The command codes on `cmd_i` are FORCE_TRX_OFF=3, FORCE_PLL_ON=4, RX_ON=6, TRX_OFF=8 and PLL_ON=9, and all other codes are ignored. RX_ON is accepted from TRX_OFF and PLL_ON. PLL_ON is accepted from TRX_OFF and RX_ON. TRX_OFF and FORCE_TRX_OFF go to TRX_OFF from P_ON, RX_ON, PLL_ON and RX_ON_NOCLK. All of these are ignored in SLEEP, and a command naming the present state is ignored.
- R6: A rising edge on `slptr_i` starts a change from TRX_OFF to SLEEP, from RX_ON to RX_ON_NOCLK, or from PLL_ON to BUSY_TX. In other states it has no effect. 0x1F first shows three cycles after the pin change is applied.
- R7: A falling edge on `slptr_i` starts a change from SLEEP to TRX_OFF or from RX_ON_NOCLK to RX_ON. In other states it has no effect.
- R8: A pin edge that is detected while 0x1F is shown is held and applied once the change completes.
- R9: `frame_start_i` in RX_ON gives BUSY_RX on the next cycle. `rx_done_i` in BUSY_RX gives RX_ON on the next cycle, and `tx_done_i` in BUSY_TX gives PLL_ON on the next cycle. None of these shows 0x1F.
- R10: FORCE_TRX_OFF in BUSY_RX or BUSY_TX gives TRX_OFF on the next cycle.
- R11: TRX_OFF in BUSY_RX or BUSY_TX leaves the state unchanged. The done strobe that ends the frame then starts a change to TRX_OFF.
- R12: FORCE_PLL_ON starts a change to PLL_ON from RX_ON, BUSY_RX or BUSY_TX and is ignored in every other state. `pll_en_o` is 1 in RX_ON, BUSY_RX, PLL_ON and BUSY_TX, and during any change toward one of those states, so it stays 1 throughout a FORCE_PLL_ON change.
- R13: `rst_pin_ni` low gives TRX_OFF on the next cycle and drops any change in progress, any stored idle command and any held edge. In the power-on state the machine stays in P_ON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_ni | input | 1 | Reset pin, active low, sampled synchronously |
| osc_stable_i | input | 1 | Oscillator has settled |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 4 | Command code |
| slptr_i | input | 1 | Sleep/transmit pin, asynchronous |
| frame_start_i | input | 1 | Receiver found a frame |
| rx_done_i | input | 1 | Receive frame finished |
| tx_done_i | input | 1 | Transmit frame finished |
| status_o | output | 5 | State code, or 0x1F while a change runs |
| clkm_valid_o | output | 1 | Master clock output is valid |
| pll_en_o | output | 1 | PLL and regulator enable |

## Verification
The bench drives a second command into the middle of a change. A design that queued it would drift into a further state afterwards. It raises the pin while a change is running. A design that dropped the edge would stay in PLL_ON instead of starting transmission. It issues the plain idle command during a received frame and checks both that the frame goes on and that the completion strobe then starts a delayed move to TRX_OFF. It also issues the forcing idle command, where a design that deferred it would stay in BUSY_RX. Random commands from the three stable working states are checked against a table function, which exposes a wrong legality rule or a delay that is off by one cycle.

// File: rtl/trx_pkg.sv
package trx_pkg;
  localparam int STAT_W = 5;
  localparam int CMD_W  = 4;

  typedef enum logic [STAT_W-1:0] {
    ST_P_ON     = 5'h00,
    ST_BUSY_RX  = 5'h01,
    ST_BUSY_TX  = 5'h02,
    ST_RX_ON    = 5'h06,
    ST_TRX_OFF  = 5'h08,
    ST_PLL_ON   = 5'h09,
    ST_SLEEP    = 5'h0F,
    ST_RX_NOCLK = 5'h1C
  } trx_state_e;

  localparam logic [STAT_W-1:0] STAT_INPROG = 5'h1F;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP       = 4'd0,
    CMD_FORCE_OFF = 4'd3,
    CMD_FORCE_PLL = 4'd4,
    CMD_RX_ON     = 4'd6,
    CMD_OFF       = 4'd8,
    CMD_PLL_ON    = 4'd9
  } trx_cmd_e;

  typedef enum logic [1:0] {
    HELD_NONE = 2'd0,
    HELD_RISE = 2'd1,
    HELD_FALL = 2'd2
  } held_edge_e;
endpackage

// File: rtl/trx_edge_sync.sv
module trx_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall_o = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];
endmodule

// File: rtl/trx_delay.sv
module trx_delay #(
  parameter int DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(DLY - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/trx_fsm.sv
module trx_fsm
  import trx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rst_pin_ni,
  input  logic                cmd_valid_i,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                frame_start_i,
  input  logic                rx_done_i,
  input  logic                tx_done_i,
  input  logic                busy_i,
  input  logic                done_i,
  output logic                load_o,
  output logic                abort_o,
  output trx_state_e          state_o,
  output trx_state_e          tgt_o
);
  trx_state_e state_q, state_d, tgt_q, tgt_d;
  held_edge_e held_q, held_d;
  logic       pend_q, pend_d;
  logic       eff_rise, eff_fall, in_frame;

  always_comb begin
    if (rise_i || fall_i) begin
      eff_rise = rise_i;
      eff_fall = fall_i;
    end else begin
      eff_rise = (held_q == HELD_RISE);
      eff_fall = (held_q == HELD_FALL);
    end
  end

  assign in_frame = (state_q == ST_BUSY_RX) || (state_q == ST_BUSY_TX);

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    pend_d  = pend_q;
    held_d  = held_q;
    load_o  = 1'b0;
    abort_o = 1'b0;
    if (!rst_pin_ni) begin
      abort_o = 1'b1;
      pend_d  = 1'b0;
      held_d  = HELD_NONE;
      if (state_q != ST_P_ON) state_d = ST_TRX_OFF;
    end else if (busy_i) begin
      if (done_i) state_d = tgt_q;
      if (rise_i)      held_d = HELD_RISE;
      else if (fall_i) held_d = HELD_FALL;
    end else begin
      held_d = HELD_NONE;
      if (in_frame && cmd_valid_i && cmd_i == CMD_FORCE_OFF) begin
        state_d = ST_TRX_OFF;
        pend_d  = 1'b0;
      end else if (state_q == ST_BUSY_RX && rx_done_i) begin
        pend_d = 1'b0;
        if (pend_q) begin load_o = 1'b1; tgt_d = ST_TRX_OFF; end
        else        state_d = ST_RX_ON;
      end else if (state_q == ST_BUSY_TX && tx_done_i) begin
        pend_d = 1'b0;
        if (pend_q) begin load_o = 1'b1; tgt_d = ST_TRX_OFF; end
        else        state_d = ST_PLL_ON;
      end else if (state_q == ST_RX_ON && frame_start_i) begin
        state_d = ST_BUSY_RX;
      end else if (eff_rise && (state_q == ST_TRX_OFF || state_q == ST_RX_ON ||
                                state_q == ST_PLL_ON)) begin
        load_o = 1'b1;
        case (state_q)
          ST_TRX_OFF: tgt_d = ST_SLEEP;
          ST_RX_ON:   tgt_d = ST_RX_NOCLK;
          default:    tgt_d = ST_BUSY_TX;
        endcase
      end else if (eff_fall && (state_q == ST_SLEEP || state_q == ST_RX_NOCLK)) begin
        load_o = 1'b1;
        tgt_d  = (state_q == ST_SLEEP) ? ST_TRX_OFF : ST_RX_ON;
      end else if (cmd_valid_i) begin
        case (cmd_i)
          CMD_FORCE_OFF, CMD_OFF: begin
            if (in_frame) pend_d = 1'b1;
            else if (state_q != ST_SLEEP && state_q != ST_TRX_OFF) begin
              load_o = 1'b1;
              tgt_d  = ST_TRX_OFF;
            end
          end
          CMD_FORCE_PLL: begin
            if (in_frame || state_q == ST_RX_ON) begin
              load_o = 1'b1;
              tgt_d  = ST_PLL_ON;
              pend_d = 1'b0;
            end
          end
          CMD_RX_ON: begin
            if (state_q == ST_TRX_OFF || state_q == ST_PLL_ON) begin
              load_o = 1'b1;
              tgt_d  = ST_RX_ON;
            end
          end
          CMD_PLL_ON: begin
            if (state_q == ST_TRX_OFF || state_q == ST_RX_ON) begin
              load_o = 1'b1;
              tgt_d  = ST_PLL_ON;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_P_ON;
      tgt_q   <= ST_TRX_OFF;
      pend_q  <= 1'b0;
      held_q  <= HELD_NONE;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      pend_q  <= pend_d;
      held_q  <= held_d;
    end
  end

  assign state_o = state_q;
  assign tgt_o   = tgt_q;
endmodule

// File: rtl/trx_state_ctrl.sv
module trx_state_ctrl
  import trx_pkg::*;
#(
  parameter int TRANS_DLY   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_ni,
  input  logic              osc_stable_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              slptr_i,
  input  logic              frame_start_i,
  input  logic              rx_done_i,
  input  logic              tx_done_i,
  output logic [STAT_W-1:0] status_o,
  output logic              clkm_valid_o,
  output logic              pll_en_o
);
  logic       rise, fall, busy, done, load, abort, clkm_q;
  trx_state_e state, tgt, eff_st;

  trx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .pin_i (slptr_i),
    .rise_o(rise),  .fall_o (fall)
  );

  trx_delay #(.DLY(TRANS_DLY)) u_dly (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (load), .abort_i (abort),
    .busy_o(busy),  .done_o (done)
  );

  trx_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rst_pin_ni   (rst_pin_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_i        (cmd_i),
    .rise_i       (rise),
    .fall_i       (fall),
    .frame_start_i(frame_start_i),
    .rx_done_i    (rx_done_i),
    .tx_done_i    (tx_done_i),
    .busy_i       (busy),
    .done_i       (done),
    .load_o       (load),
    .abort_o      (abort),
    .state_o      (state),
    .tgt_o        (tgt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clkm_q <= 1'b0;
    else         clkm_q <= clkm_q | osc_stable_i;
  end

  assign eff_st       = busy ? tgt : state;
  assign status_o     = busy ? STAT_INPROG : state;
  assign clkm_valid_o = clkm_q && !(state == ST_SLEEP && !busy);
  assign pll_en_o     = (eff_st == ST_RX_ON) || (eff_st == ST_BUSY_RX) ||
                        (eff_st == ST_PLL_ON) || (eff_st == ST_BUSY_TX);
endmodule

// File: rtl/trx_state_ctrl_chk.sv
module trx_state_ctrl_chk #(
  parameter int TRANS_DLY = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rst_pin_ni,
  input logic       cmd_valid_i,
  input logic [3:0] cmd_i,
  input logic       frame_start_i,
  input logic       tx_done_i,
  input logic [4:0] status_o,
  input logic       clkm_valid_o
);
  localparam int RW = $clog2(TRANS_DLY + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  run_q <= '0;
    else if (status_o != 5'h1F)                   run_q <= '0;
    else if (run_q != {RW{1'b1}})                 run_q <= run_q + 1'b1;
  end

  a_r3_window_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 5'h1F && $past(status_o) == 5'h1F && $past(rst_pin_ni))
      |-> run_q == RW'(TRANS_DLY));

  a_r3_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o inside {5'h00, 5'h01, 5'h02, 5'h06, 5'h08, 5'h09, 5'h0F, 5'h1C, 5'h1F});

  a_r2_no_clk_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 5'h0F |-> !clkm_valid_o);

  a_r9_frame_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_pin_ni && status_o == 5'h06 && frame_start_i) |=> status_o == 5'h01);

  a_r9_tx_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_pin_ni && status_o == 5'h02 && tx_done_i && !(cmd_valid_i && cmd_i == 4'd3))
      |=> (status_o == 5'h09 || status_o == 5'h1F));

  a_r10_force_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_pin_ni && cmd_valid_i && cmd_i == 4'd3 && (status_o == 5'h01 || status_o == 5'h02))
      |=> status_o == 5'h08);

  a_r13_pin_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_pin_ni && status_o != 5'h00 && status_o != 5'h1F) |=> status_o == 5'h08);

  a_r13_keep_pon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_pin_ni && status_o == 5'h00) |=> status_o == 5'h00);
endmodule

bind trx_state_ctrl trx_state_ctrl_chk #(.TRANS_DLY(TRANS_DLY)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rst_pin_ni   (rst_pin_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_i        (cmd_i),
  .frame_start_i(frame_start_i),
  .tx_done_i    (tx_done_i),
  .status_o     (status_o),
  .clkm_valid_o (clkm_valid_o)
);

// File: tb/sim_trx_state_ctrl.sv
module sim_trx_state_ctrl;
  localparam int D = 3;

  logic       clk = 1'b0;
  logic       rst_ni, rst_pin_ni, osc_stable_i, cmd_valid_i, slptr_i;
  logic       frame_start_i, rx_done_i, tx_done_i;
  logic [3:0] cmd_i;
  logic [4:0] status_o;
  logic       clkm_valid_o, pll_en_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  trx_state_ctrl #(.TRANS_DLY(D)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rst_pin_ni(rst_pin_ni), .osc_stable_i(osc_stable_i),
    .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i), .slptr_i(slptr_i),
    .frame_start_i(frame_start_i), .rx_done_i(rx_done_i), .tx_done_i(tx_done_i),
    .status_o(status_o), .clkm_valid_o(clkm_valid_o), .pll_en_o(pll_en_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [3:0] c);
    @(negedge clk); cmd_valid_i = 1'b1; cmd_i = c;
    @(negedge clk); cmd_valid_i = 1'b0; cmd_i = 4'd0;
  endtask

  // called one cycle after acceptance
  task automatic finish(string req, logic [4:0] exp);
    chk(req, status_o, 5'h1F);
    idle(D - 1);
    chk(req, status_o, 5'h1F);
    idle(1);
    chk(req, status_o, exp);
  endtask

  task automatic send_trans(string req, logic [3:0] c, logic [4:0] exp);
    send(c);
    finish(req, exp);
  endtask

  task automatic pin_trans(string req, logic v, logic [4:0] exp);
    @(negedge clk); slptr_i = v;
    idle(3);
    finish(req, exp);
  endtask

  task automatic pulse_fs();
    @(negedge clk); frame_start_i = 1'b1; @(negedge clk); frame_start_i = 1'b0;
  endtask
  task automatic pulse_rx();
    @(negedge clk); rx_done_i = 1'b1; @(negedge clk); rx_done_i = 1'b0;
  endtask
  task automatic pulse_tx();
    @(negedge clk); tx_done_i = 1'b1; @(negedge clk); tx_done_i = 1'b0;
  endtask

  function automatic logic [4:0] exp_next(logic [4:0] s, logic [3:0] c);
    case (s)
      5'h08: exp_next = (c == 4'd6) ? 5'h06 : (c == 4'd9) ? 5'h09 : s;
      5'h06: exp_next = (c == 4'd3 || c == 4'd8) ? 5'h08 :
                        (c == 4'd9 || c == 4'd4) ? 5'h09 : s;
      5'h09: exp_next = (c == 4'd3 || c == 4'd8) ? 5'h08 : (c == 4'd6) ? 5'h06 : s;
      default: exp_next = s;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] cur;
    void'($urandom(32'h5A17));
    rst_ni = 1'b0; rst_pin_ni = 1'b1; osc_stable_i = 1'b0; cmd_valid_i = 1'b0;
    cmd_i = 4'd0; slptr_i = 1'b0; frame_start_i = 1'b0; rx_done_i = 1'b0; tx_done_i = 1'b0;
    idle(2);
    chk("R1 status in reset", status_o, 5'h00);
    rst_ni = 1'b1;
    idle(1);
    chk("R1 status", status_o, 5'h00);
    chk("R1 clkm", clkm_valid_o, 0);
    chk("R1 pll", pll_en_o, 0);

    send(4'd6); idle(D + 1);
    chk("R5 rx_on ignored in p_on", status_o, 5'h00);
    @(negedge clk); rst_pin_ni = 1'b0;
    @(negedge clk); rst_pin_ni = 1'b1;
    chk("R13 p_on kept", status_o, 5'h00);
    @(negedge clk); osc_stable_i = 1'b1;
    @(negedge clk);
    chk("R2 clkm valid", clkm_valid_o, 1);

    send_trans("R3 p_on to trx_off", 4'd8, 5'h08);
    send(4'd4); idle(D + 1);
    chk("R12 force_pll ignored in trx_off", status_o, 5'h08);
    chk("R12 pll off", pll_en_o, 0);

    send(4'd9);
    chk("R4 in progress", status_o, 5'h1F);
    send(4'd6);
    idle(1);
    chk("R4 pll_on reached", status_o, 5'h09);
    idle(D + 2);
    chk("R4 late command dropped", status_o, 5'h09);
    chk("R12 pll on", pll_en_o, 1);

    pin_trans("R6 pll_on to busy_tx", 1'b1, 5'h02);
    pulse_tx();
    chk("R9 tx_done", status_o, 5'h09);
    @(negedge clk); slptr_i = 1'b0; idle(D + 4);
    chk("R7 fall no effect in pll_on", status_o, 5'h09);

    send_trans("R5 pll_on to rx_on", 4'd6, 5'h06);
    pulse_fs();
    chk("R9 frame_start", status_o, 5'h01);
    send(4'd8); idle(D + 1);
    chk("R11 off deferred", status_o, 5'h01);
    pulse_rx();
    finish("R11 off after frame", 5'h08);

    send_trans("R5 trx_off to rx_on", 4'd6, 5'h06);
    pulse_fs();
    send(4'd3);
    chk("R10 force off", status_o, 5'h08);

    send_trans("R5 rx_on", 4'd6, 5'h06);
    pulse_fs();
    pulse_rx();
    chk("R9 rx_done", status_o, 5'h06);
    pulse_fs();
    send(4'd4);
    chk("R12 pll kept in force", pll_en_o, 1);
    finish("R12 force_pll from busy_rx", 5'h09);
    chk("R12 pll after force", pll_en_o, 1);

    send_trans("R5 pll_on to trx_off", 4'd8, 5'h08);
    pin_trans("R6 trx_off to sleep", 1'b1, 5'h0F);
    chk("R2 clkm low in sleep", clkm_valid_o, 0);
    send(4'd8); send(4'd3); idle(D + 1);
    chk("R5 off ignored in sleep", status_o, 5'h0F);
    pin_trans("R7 sleep to trx_off", 1'b0, 5'h08);
    chk("R2 clkm back", clkm_valid_o, 1);

    send_trans("R5 rx_on again", 4'd6, 5'h06);
    pin_trans("R6 rx_on to noclk", 1'b1, 5'h1C);
    send(4'd4); idle(D + 1);
    chk("R12 force_pll ignored in noclk", status_o, 5'h1C);
    pin_trans("R7 noclk to rx_on", 1'b0, 5'h06);

    send(4'd9);
    slptr_i = 1'b1;
    idle(D + 10);
    chk("R8 held edge applied", status_o, 5'h02);
    pulse_tx();
    chk("R9 tx_done again", status_o, 5'h09);
    @(negedge clk); slptr_i = 1'b0; idle(D + 4);

    send_trans("R5 rx_on before pin reset", 4'd6, 5'h06);
    @(negedge clk); rst_pin_ni = 1'b0;
    @(negedge clk); rst_pin_ni = 1'b1;
    chk("R13 pin reset", status_o, 5'h08);
    send(4'd6);
    rst_pin_ni = 1'b0;
    @(negedge clk); rst_pin_ni = 1'b1;
    chk("R13 abort change", status_o, 5'h08);
    idle(D + 2);
    chk("R13 change dropped", status_o, 5'h08);

    cur = 5'h08;
    for (int i = 0; i < 150; i++) begin
      logic [3:0] c;
      logic [4:0] e;
      c = 4'($urandom_range(0, 15));
      e = exp_next(cur, c);
      send(c);
      if (e != cur) finish("R5 random", e);
      else begin
        idle(D);
        chk("R5 random ignored", status_o, cur);
      end
      cur = e;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule